// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block gathers up to forty external interrupt lines and turns them into forty interrupt outputs, one per line. The lines are grouped into banks of thirty-two, and each bank has its own group of six word registers in a 1 KiB window. A fixed build-time map splits the valid lines into two kinds. A direct line copies its input level to its output while it is unmasked. A configurable line watches for the rising and/or falling edges that software selects. It latches a pending flag, emits a one-cycle output pulse on each qualifying edge, can also be fired by software, and has its flag cleared by writing 1.

Every input passes through a two-flop synchronizer. The synchronized level is then compared with a stored copy of the previous level, so an event is seen only when the level really changes. The stored copy is refreshed every cycle, whether or not the line is unmasked. The register port has one cycle per access, with a valid strobe, a write flag, a byte address, write data and combinational read data. The event mask register is kept and read back, and it drives nothing.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset each bank's unmask register holds that bank's direct-line map (bank 0 0xFF820000, bank 1 0x00000087). The event mask, rising select, falling select, software trigger, pending and stored line levels are all zero, and every interrupt output is low.
- R2: A write to the unmask or event mask register keeps only the valid-line bits (all 32 in bank 0, bits 7:0 in bank 1). A write to rising select, falling select, software trigger or pending keeps only the configurable bits, which are the valid bits that are not direct. Lines beyond the last valid line never raise an output.
- R3: Within a bank the register offsets are unmask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10 and pending 0x14. Bank k starts at byte 0x20*k. Line n sits in bank n/32 at bit n%32.
- R4: Only word-aligned accesses to a mapped register take effect. A read of an unaligned address, of offsets 0x18 and 0x1C within a bank, or of a bank past the last returns 0. A write to any of these changes nothing.
- R5: A line change is acted on only after the two-flop synchronizer. An input that changes before clock edge E0 gives an output change on edge E2, and a configurable pulse falls again on edge E3.
- R6: On an unmasked configurable line, a rising edge with its rising-select bit set, or a falling edge with its falling-select bit set, sets the pending bit and raises that line's output for exactly one cycle. This happens even if the bit is already pending.
- R7: A change on a line whose unmask bit is 0 sets no pending bit and raises no output. The stored level is still updated, so unmasking the line later produces no event by itself.
- R8: On an unmasked direct line, each level change is copied to the output and no pending bit is set. While the line is masked, its output holds its last value.
- R9: A software-trigger write stores its masked value. Each bit that goes from 0 to 1, is unmasked and is not already pending sets its pending bit and gives a one-cycle output pulse. Writing the same 1 again fires nothing.
- R10: Writing 1 to a set pending bit clears that bit and the matching software-trigger bit. Writing 0 changes nothing. An edge event in the same cycle as the clear wins, and the bit stays set.
- R11: The event mask register is stored and read back, and it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address in the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, 0 otherwise |
| irq_o | output | NUM_LINES | Per-line interrupt outputs (level for direct lines, pulse for configurable lines) |

## Verification
Directed patterns set a single rising edge, a single falling edge, and a rise on a line whose falling select alone is set. Together these separate the two edge selectors from each other and from plain level changes. Toggling a line while it is masked and then unmasking it shows whether the stored level follows the input regardless of the mask. Direct lines are toggled both while unmasked and while masked, to tell level following apart from holding. Software triggers are written twice with the same value, to separate 0-to-1 firing from level firing. Long random mixes of line toggles and register writes then check every output cycle by cycle against a bench model, which exposes any wrong ordering between same-cycle clears, triggers and edges.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_UNMASK = 3'd0,
    SEL_EVMASK = 3'd1,
    SEL_RISE   = 3'd2,
    SEL_FALL   = 3'd3,
    SEL_SWTRIG = 3'd4,
    SEL_PEND   = 3'd5
  } reg_sel_e;

  // valid bits of a bank serving 'lines' lines
  function automatic logic [BANK_W-1:0] valid_bits(input int unsigned lines);
    return BANK_W'((64'd1 << lines) - 64'd1);
  endfunction

  // selected edges between the stored and the current level
  function automatic logic [BANK_W-1:0] edge_hits(
    input logic [BANK_W-1:0] now_lvl,
    input logic [BANK_W-1:0] old_lvl,
    input logic [BANK_W-1:0] rise_sel,
    input logic [BANK_W-1:0] fall_sel);
    return (now_lvl & ~old_lvl & rise_sel) | (~now_lvl & old_lvl & fall_sel);
  endfunction

  // software trigger bits that newly go high on enabled, idle lines
  function automatic logic [BANK_W-1:0] sw_fresh(
    input logic [BANK_W-1:0] wr_val,
    input logic [BANK_W-1:0] prev,
    input logic [BANK_W-1:0] enabled,
    input logic [BANK_W-1:0] pending);
    return wr_val & ~prev & enabled & ~pending;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
`timescale 1ns/1ps
module ext_irq_sync #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/ext_irq_bank.sv
`timescale 1ns/1ps
module ext_irq_bank
  import ext_irq_pkg::*;
#(
  parameter int unsigned       LINES       = 32,
  parameter logic [BANK_W-1:0] DIRECT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lvl_i,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BANK_W-1:0] q_unmask,
  output logic [BANK_W-1:0] q_evmask,
  output logic [BANK_W-1:0] q_rise,
  output logic [BANK_W-1:0] q_fall,
  output logic [BANK_W-1:0] q_swtrig,
  output logic [BANK_W-1:0] q_pend,
  output logic [BANK_W-1:0] irq_o
);
  localparam logic [BANK_W-1:0] VALID_M  = valid_bits(LINES);
  localparam logic [BANK_W-1:0] DIRECT_V = VALID_M & DIRECT_MASK;
  localparam logic [BANK_W-1:0] CFG_M    = VALID_M & ~DIRECT_MASK;

  logic [BANK_W-1:0] unmask_q, evmask_q, rise_q, fall_q, swtrig_q, pend_q;
  logic [BANK_W-1:0] lvl_q, dir_q, pulse_q;

  // named internal events
  logic              wr_sw, wr_pd;
  logic [BANK_W-1:0] chg, hw_hit, sw_hit, clr_bits, dir_upd;

  reg_sel_e sel;
  assign sel      = reg_sel_e'(wr_sel);
  assign wr_sw    = wr_en && (sel == SEL_SWTRIG);
  assign wr_pd    = wr_en && (sel == SEL_PEND);
  assign chg      = lvl_i ^ lvl_q;
  assign hw_hit   = unmask_q & CFG_M & edge_hits(lvl_i, lvl_q, rise_q, fall_q);
  assign sw_hit   = wr_sw ? sw_fresh(wr_data & CFG_M, swtrig_q, unmask_q, pend_q) : '0;
  assign clr_bits = wr_pd ? (pend_q & wr_data & CFG_M) : '0;
  assign dir_upd  = chg & unmask_q & DIRECT_V;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unmask_q <= DIRECT_V;
      evmask_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_UNMASK: unmask_q <= wr_data & VALID_M;
        SEL_EVMASK: evmask_q <= wr_data & VALID_M;
        SEL_RISE:   rise_q   <= wr_data & CFG_M;
        SEL_FALL:   fall_q   <= wr_data & CFG_M;
        default: ;
      endcase
    end
  end

  // level history, pending, software trigger and outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      pend_q   <= '0;
      swtrig_q <= '0;
      dir_q    <= '0;
      pulse_q  <= '0;
    end else begin
      lvl_q   <= lvl_i;
      pend_q  <= (pend_q & ~clr_bits) | hw_hit | sw_hit;
      dir_q   <= (dir_q & ~dir_upd) | (lvl_i & dir_upd);
      pulse_q <= hw_hit | sw_hit;
      if (wr_sw)      swtrig_q <= wr_data & CFG_M;
      else if (wr_pd) swtrig_q <= swtrig_q & ~clr_bits;
    end
  end

  assign q_unmask = unmask_q;
  assign q_evmask = evmask_q;
  assign q_rise   = rise_q;
  assign q_fall   = fall_q;
  assign q_swtrig = swtrig_q;
  assign q_pend   = pend_q;
  assign irq_o    = (dir_q & DIRECT_V) | (pulse_q & CFG_M);

  // R6: every configurable pulse comes with its pending bit
  a_r6_pulse_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & CFG_M) != '0) |-> ((irq_o & CFG_M & ~q_pend) == '0));

  // R7: with no register write, masked lines never pulse
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ((irq_o & CFG_M & ~$past(unmask_q)) == '0));

  // R8: an unmasked direct line change reaches the output next cycle
  a_r8_direct_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_upd != '0) |=> (((irq_o ^ $past(lvl_i)) & $past(dir_upd)) == '0));

  // R9: a fresh software trigger pulses its lines next cycle
  a_r9_sw_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hit != '0) |=> ((irq_o & $past(sw_hit)) == $past(sw_hit)));

  // R10: a clear with no colliding edge empties pending and trigger bits
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_bits != '0) && ((hw_hit & clr_bits) == '0))
      |=> (((q_pend | q_swtrig) & $past(clr_bits)) == '0));
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned      NUM_LINES  = 40,
  parameter logic [NUM_LINES-1:0] DIRECT_MAP = 40'h87_FF82_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [9:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned NBANK  = (NUM_LINES + BANK_W - 1) / BANK_W;
  localparam int unsigned PAD    = NBANK * BANK_W;
  localparam logic [PAD-1:0] DIR_PAD = PAD'(DIRECT_MAP);
  localparam int unsigned LAST_SEL = 5;

  logic [NUM_LINES-1:0] sync_lvl;
  logic [PAD-1:0]       lvl_pad;
  logic [PAD-1:0]       irq_pad;
  logic [4:0]           bank_idx;
  logic [SEL_W-1:0]     reg_idx;
  logic                 addr_hit;
  logic [BANK_W-1:0]    rd_bank [NBANK];

  ext_irq_sync #(.W(NUM_LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (line_i),
    .sync_o  (sync_lvl)
  );

  always_comb begin
    lvl_pad = '0;
    lvl_pad[NUM_LINES-1:0] = sync_lvl;
  end

  assign bank_idx = bus_addr[9:5];
  assign reg_idx  = bus_addr[4:2];
  assign addr_hit = (bus_addr[1:0] == 2'b00) && (32'(bank_idx) < NBANK)
                 && (32'(reg_idx) <= LAST_SEL);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int unsigned BL =
      (NUM_LINES - BANK_W*b >= BANK_W) ? BANK_W : NUM_LINES - BANK_W*b;
    logic [BANK_W-1:0] r_unm, r_ev, r_ri, r_fa, r_sw, r_pd;
    logic              wr_here;

    assign wr_here = bus_valid && bus_write && addr_hit && (bank_idx == 5'(b));

    ext_irq_bank #(
      .LINES       (BL),
      .DIRECT_MASK (DIR_PAD[BANK_W*b +: BANK_W])
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (lvl_pad[BANK_W*b +: BANK_W]),
      .wr_en    (wr_here),
      .wr_sel   (reg_idx),
      .wr_data  (bus_wdata),
      .q_unmask (r_unm),
      .q_evmask (r_ev),
      .q_rise   (r_ri),
      .q_fall   (r_fa),
      .q_swtrig (r_sw),
      .q_pend   (r_pd),
      .irq_o    (irq_pad[BANK_W*b +: BANK_W])
    );

    always_comb begin
      case (reg_sel_e'(reg_idx))
        SEL_UNMASK: rd_bank[b] = r_unm;
        SEL_EVMASK: rd_bank[b] = r_ev;
        SEL_RISE:   rd_bank[b] = r_ri;
        SEL_FALL:   rd_bank[b] = r_fa;
        SEL_SWTRIG: rd_bank[b] = r_sw;
        SEL_PEND:   rd_bank[b] = r_pd;
        default:    rd_bank[b] = '0;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write && addr_hit) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bank_idx == 5'(b)) bus_rdata = rd_bank[b];
      end
    end
  end

  assign irq_o = irq_pad[NUM_LINES-1:0];

  // R2: padding lines past the last valid line never interrupt
  a_r2_no_phantom_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pad >> NUM_LINES) == '0));

  // R4: reads outside the mapped registers return zero
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !addr_hit) |-> (bus_rdata == 32'd0));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] line_i = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [39:0] irq_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  logic [39:0] cur_lines = '0;

  // bench model
  logic [31:0] m_unm [2], m_ev [2], m_ri [2], m_fa [2], m_sw [2], m_pr [2];
  logic [31:0] m_dir [2], m_pul [2];
  logic [63:0] m_s1, m_s2, m_lvl;

  always #5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] vmask(input int b);
    return (b == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
  endfunction
  function automatic logic [31:0] dmask(input int b);
    return (b == 0) ? 32'hFF82_0000 : 32'h0000_0087;
  endfunction
  function automatic logic [31:0] cmask(input int b);
    return vmask(b) & ~dmask(b);
  endfunction

  function automatic bit mapped(input logic [9:0] a);
    return (a[1:0] == 2'b00) && (a[9:6] == 4'd0) && (a[4:2] <= 3'd5);
  endfunction

  function automatic logic [31:0] model_read(input logic [9:0] a);
    int b;
    if (!mapped(a)) return 32'd0;
    b = int'(a[5]);
    case (a[4:2])
      3'd0: return m_unm[b];
      3'd1: return m_ev[b];
      3'd2: return m_ri[b];
      3'd3: return m_fa[b];
      3'd4: return m_sw[b];
      default: return m_pr[b];
    endcase
  endfunction

  function automatic logic [39:0] exp_irq();
    logic [63:0] e;
    e[31:0]  = (m_dir[0] & dmask(0)) | (m_pul[0] & cmask(0));
    e[63:32] = (m_dir[1] & dmask(1)) | (m_pul[1] & cmask(1));
    return e[39:0];
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      m_unm[b] = dmask(b); m_ev[b] = '0; m_ri[b] = '0; m_fa[b] = '0;
      m_sw[b] = '0; m_pr[b] = '0; m_dir[b] = '0; m_pul[b] = '0;
    end
    m_s1 = '0; m_s2 = '0; m_lvl = '0;
  endtask

  // one clock edge of the expected behaviour
  task automatic model_step(input logic [39:0] ln, input logic v, w,
                            input logic [9:0] a, input logic [31:0] d);
    for (int b = 0; b < 2; b++) begin
      logic [31:0] s, l, hw, sw, clr, upd;
      s = m_s2[32*b +: 32];
      l = m_lvl[32*b +: 32];
      hw = m_unm[b] & cmask(b) & ((s & ~l & m_ri[b]) | (~s & l & m_fa[b]));
      upd = (s ^ l) & m_unm[b] & dmask(b);
      sw = '0; clr = '0;
      if (v && w && mapped(a) && int'(a[5]) == b) begin
        case (a[4:2])
          3'd0: m_unm[b] = d & vmask(b);
          3'd1: m_ev[b]  = d & vmask(b);
          3'd2: m_ri[b]  = d & cmask(b);
          3'd3: m_fa[b]  = d & cmask(b);
          3'd4: begin
            sw = d & cmask(b) & ~m_sw[b] & m_unm[b] & ~m_pr[b];
            m_sw[b] = d & cmask(b);
          end
          default: begin
            clr = m_pr[b] & d & cmask(b);
            m_sw[b] = m_sw[b] & ~clr;
          end
        endcase
      end
      m_pr[b]  = (m_pr[b] & ~clr) | hw | sw;
      m_dir[b] = (m_dir[b] & ~upd) | (s & upd);
      m_pul[b] = hw | sw;
    end
    m_lvl = m_s2;
    m_s2  = m_s1;
    m_s1  = {24'd0, ln};
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, w, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    line_i = cur_lines; bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    #1;
    if (v && !w) chk(cur_req, 64'(bus_rdata), 64'(model_read(a)));
    model_step(cur_lines, v, w, a, d);
    @(posedge clk);
    #1;
    chk(cur_req, 64'(irq_o), 64'(exp_irq()));
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d);
  endtask
  task automatic rd(input logic [9:0] a);
    step(1'b1, 1'b0, a, 32'd0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 10'd0, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    for (int r = 0; r < 6; r++) begin
      rd(10'(4*r));
      rd(10'(32 + 4*r));
    end

    // R11 event mask stored only, R2 masking
    cur_req = "R11";
    wr(10'h04, 32'hA5A5_A5A5); rd(10'h04);
    wr(10'h24, 32'hFFFF_FFFF); rd(10'h24);
    cur_req = "R2";
    wr(10'h08, 32'hFFFF_FFFF); rd(10'h08);
    wr(10'h0C, 32'hFFFF_FFFF); rd(10'h0C);
    wr(10'h28, 32'hFFFF_FFFF); rd(10'h28);
    wr(10'h20, 32'hFFFF_FFFF); rd(10'h20);
    wr(10'h00, 32'h0000_0000); rd(10'h00);

    // R4 unmapped and unaligned
    cur_req = "R4";
    rd(10'h18); rd(10'h3C); rd(10'h40); rd(10'h3FC); rd(10'h001);
    wr(10'h40, 32'hFFFF_FFFF); rd(10'h00);
    wr(10'h01, 32'hFFFF_FFFF); rd(10'h00);

    // clean setup: unmask bank 0, rise on line 0, fall on line 1
    cur_req = "R2";
    wr(10'h00, 32'hFFFF_FFFF);
    wr(10'h08, 32'h0000_0001);
    wr(10'h0C, 32'h0000_0002);
    wr(10'h28, 32'h0000_0000);
    wr(10'h2C, 32'h0000_0000);

    // R5 timing of a rising edge, R6 pending
    cur_req = "R5";
    cur_lines[0] = 1'b1;
    idle(4);
    cur_req = "R6";
    rd(10'h14);
    cur_lines[1] = 1'b1; idle(4); rd(10'h14);
    cur_lines[1] = 1'b0; idle(4); rd(10'h14);
    cur_lines[0] = 1'b0; idle(4); rd(10'h14);

    // R10 write-one-to-clear
    cur_req = "R10";
    wr(10'h14, 32'h0); rd(10'h14);
    wr(10'h14, 32'h1); rd(10'h14);
    wr(10'h14, 32'hFFFF_FFFF); rd(10'h14);

    // R7 masked line tracks level silently
    cur_req = "R7";
    wr(10'h00, 32'hFFFF_FFFB);
    wr(10'h08, 32'h0000_0004);
    cur_lines[2] = 1'b1; idle(4); rd(10'h14);
    wr(10'h00, 32'hFFFF_FFFF); idle(4); rd(10'h14);

    // R8 direct lines
    cur_req = "R8";
    cur_lines[17] = 1'b1; idle(4); rd(10'h14);
    wr(10'h00, 32'hFFFD_FFFF);
    cur_lines[17] = 1'b0; idle(4);
    wr(10'h00, 32'hFFFF_FFFF);
    cur_lines[17] = 1'b1; idle(4);
    cur_lines[17] = 1'b0; idle(4);
    cur_lines[32] = 1'b1; idle(4); rd(10'h34);

    // R9 software trigger
    cur_req = "R9";
    wr(10'h10, 32'h0000_0008); idle(2); rd(10'h14); rd(10'h10);
    wr(10'h10, 32'h0000_0008); idle(2); rd(10'h14);
    wr(10'h10, 32'h0002_0000); idle(2); rd(10'h10);
    cur_req = "R10";
    wr(10'h10, 32'h0000_0008);
    wr(10'h14, 32'h0000_0008); rd(10'h14); rd(10'h10);

    // R3 second bank layout: line 35 is bank 1 bit 3
    cur_req = "R3";
    wr(10'h20, 32'h0000_00FF);
    wr(10'h28, 32'h0000_0008);
    cur_lines[35] = 1'b1; idle(4); rd(10'h34); rd(10'h14);

    // random mix, checked every cycle against the model
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 4) begin
        cur_lines = cur_lines ^ (40'({$urandom, $urandom}) & 40'({$urandom, $urandom})
                                 & 40'({$urandom, $urandom}));
        idle(1);
      end else if (op < 7) begin
        logic [9:0] a;
        logic [31:0] d;
        a = {4'd0, 1'($urandom), 3'($urandom % 6), 2'b00};
        d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
        wr(a, d);
      end else if (op < 9) begin
        rd({4'd0, 1'($urandom), 3'($urandom % 8), 2'b00});
      end else begin
        step(1'b1, 1'($urandom), 10'($urandom), $urandom);
      end
    end
    idle(4);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule